// File: doc/BRIEF.md
# Programmable clamp pulse generator

This block produces the clamp window that a video front end uses for DC restoration of three colour channels. In internal mode it measures from the trailing edge of horizontal sync. It waits a programmed placement count of pixel clocks and then holds the clamp for a programmed duration count. In external mode a clamp pin drives the window instead. That pin's active level is set by a polarity bit.

For every channel the block also presents the code level that the restoration should reach. The level is zero for RGB-style black and midscale for colour-difference signals. A separate select bit picks it per channel. The analog clamp switch lies outside the block. All configuration inputs are static levels that a register file holds.

Top module: `clamp_window_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `clampOut` is low.
- R2: In internal mode (`useExtClamp`=0), a trailing sync edge is sampled at posedge E0. `clampOut` then rises after posedge E0+`placeCnt`. A `placeCnt` of 0 makes it rise at E0 itself.
- R3: In internal mode, `clampOut` stays high for exactly `widthCnt` pixel clocks and falls after posedge E0+`placeCnt`+`widthCnt`.
- R4: A `widthCnt` of 0 at the trailing edge produces no clamp pulse for that line.
- R5: Sync is active when `syncIn` equals `syncActHigh`. The trailing edge is the change from active to inactive. It is a falling edge for `syncActHigh`=1 and a rising edge for `syncActHigh`=0.
- R6: A new trailing edge during a pending or running window restarts the placement count from that edge.
- R7: In external mode, `clampOut` is registered one cycle after `extClampIn`. It is high when `extClampIn` equals `extClampActHigh` and low otherwise.
- R8: In internal mode, `extClampIn` has no effect on `clampOut`.
- R9: After any clock edge at which sync was sampled active, `clampOut` is low. A leading sync edge also ends an internal window that is in progress.
- R10: Channel i occupies bits [8i+7:8i] of `clampTarget`. It reads 80h when `midSel[i]`=1 and 00h when `midSel[i]`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Horizontal sync level |
| syncActHigh | input | 1 | 1: sync active high, 0: active low |
| extClampIn | input | 1 | External clamp pin |
| extClampActHigh | input | 1 | Active sense of the external clamp pin |
| useExtClamp | input | 1 | 1: external pin drives the window, 0: internal timing |
| placeCnt | input | 8 | Pixel clocks from trailing edge to clamp start |
| widthCnt | input | 8 | Clamp length in pixel clocks |
| midSel | input | 3 | Per-channel midscale target select |
| clampOut | output | 1 | Registered clamp window |
| clampTarget | output | 24 | Three 8-bit restore target codes |

## Verification
The hardest state to reach is a trailing edge that arrives while a window is still pending or running. A second short sync pulse must land inside the placement wait, or inside the held clamp. The bench places such a pulse a few clocks after the first trailing edge. It then measures the rise relative to the second edge only. It also raises sync in the middle of a held clamp to confirm that the window aborts. A table of placement, duration and polarity combinations, including zero placement and zero duration, drives the plain timing cases.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } clampState_e;

  typedef struct packed {
    logic loadPlace;
    logic loadWidth;
    logic widthFromLive;
    logic decr;
    logic clampNext;
  } clampStrobe_t;

endpackage

// File: rtl/clamp_ctrl.sv
module clamp_ctrl
  import clamp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic             syncActHigh,
  input  logic             extClampIn,
  input  logic             extClampActHigh,
  input  logic             useExtClamp,
  input  logic [CNT_W-1:0] placeCnt,
  input  logic [CNT_W-1:0] widthCnt,
  input  logic             cntZero,
  output clampStrobe_t     strb
);

  clampState_e state, nextState;
  logic syncActive, prevActive, trailEdge, extActive;

  assign syncActive = syncIn ~^ syncActHigh;
  assign extActive  = extClampIn ~^ extClampActHigh;
  assign trailEdge  = prevActive & ~syncActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      state      <= ST_IDLE;
    end else begin
      prevActive <= syncActive;
      state      <= nextState;
    end
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    if (useExtClamp) begin
      nextState      = ST_IDLE;
      strb.clampNext = extActive & ~syncActive;
    end else if (syncActive) begin
      nextState = ST_IDLE;
    end else if (trailEdge) begin
      if (widthCnt == '0) begin
        nextState = ST_IDLE;
      end else if (placeCnt == '0) begin
        nextState          = ST_HOLD;
        strb.loadWidth     = 1'b1;
        strb.widthFromLive = 1'b1;
        strb.clampNext     = 1'b1;
      end else begin
        nextState      = ST_WAIT;
        strb.loadPlace = 1'b1;
      end
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (cntZero) begin
            nextState      = ST_HOLD;
            strb.loadWidth = 1'b1;
            strb.clampNext = 1'b1;
          end else begin
            strb.decr = 1'b1;
          end
        end
        ST_HOLD: begin
          if (cntZero) begin
            nextState = ST_IDLE;
          end else begin
            strb.decr      = 1'b1;
            strb.clampNext = 1'b1;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && $past(state) != ST_HOLD) |-> ($past(trailEdge) || $past(state) == ST_WAIT)); // R2

  AST_ZERO_WIDTH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (trailEdge && !useExtClamp && widthCnt == '0) |=> (state == ST_IDLE)); // R4

endmodule

// File: rtl/clamp_datapath.sv
module clamp_datapath
  import clamp_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PIX_W  = 8,
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  clampStrobe_t            strb,
  input  logic [CNT_W-1:0]        placeCnt,
  input  logic [CNT_W-1:0]        widthCnt,
  input  logic [NUM_CH-1:0]       midSel,
  output logic                    cntZero,
  output logic                    clampOut,
  output logic [NUM_CH*PIX_W-1:0] clampTarget
);

  localparam logic [PIX_W-1:0] MID_CODE  = PIX_W'(1) << (PIX_W - 1);
  localparam logic [PIX_W-1:0] ZERO_CODE = '0;

  logic [CNT_W-1:0] cnt, widthHold, widthSrc;

  assign widthSrc = strb.widthFromLive ? widthCnt : widthHold;
  assign cntZero  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      widthHold <= '0;
      clampOut  <= 1'b0;
    end else begin
      clampOut <= strb.clampNext;
      if (strb.loadPlace) begin
        cnt       <= placeCnt - CNT_W'(1);
        widthHold <= widthCnt;
      end else if (strb.loadWidth) begin
        cnt <= widthSrc - CNT_W'(1);
      end else if (strb.decr) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_target
    assign clampTarget[ch*PIX_W +: PIX_W] = midSel[ch] ? MID_CODE : ZERO_CODE;
  end

  AST_CNT_DECR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.decr) && !$past(strb.loadPlace) && !$past(strb.loadWidth)) |-> (cnt == $past(cnt) - CNT_W'(1))); // R3

endmodule

// File: rtl/clamp_window_top.sv
module clamp_window_top
  import clamp_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PIX_W  = 8,
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    syncIn,
  input  logic                    syncActHigh,
  input  logic                    extClampIn,
  input  logic                    extClampActHigh,
  input  logic                    useExtClamp,
  input  logic [CNT_W-1:0]        placeCnt,
  input  logic [CNT_W-1:0]        widthCnt,
  input  logic [NUM_CH-1:0]       midSel,
  output logic                    clampOut,
  output logic [NUM_CH*PIX_W-1:0] clampTarget
);

  clampStrobe_t strb;
  logic cntZero;

  clamp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .syncActHigh(syncActHigh),
    .extClampIn(extClampIn), .extClampActHigh(extClampActHigh),
    .useExtClamp(useExtClamp), .placeCnt(placeCnt), .widthCnt(widthCnt),
    .cntZero(cntZero), .strb(strb)
  );

  clamp_datapath #(.CNT_W(CNT_W), .PIX_W(PIX_W), .NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .placeCnt(placeCnt),
    .widthCnt(widthCnt), .midSel(midSel), .cntZero(cntZero),
    .clampOut(clampOut), .clampTarget(clampTarget)
  );

  AST_SYNC_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn == syncActHigh) |=> !clampOut); // R9

  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    useExtClamp |=> (clampOut == ($past(extClampIn == extClampActHigh) && !$past(syncIn == syncActHigh)))); // R7

endmodule

// File: tb/tb_clamp_window_top.sv
module tb_clamp_window_top;

  logic clk = 1'b0;
  logic rstN;
  logic syncIn, syncActHigh, extClampIn, extClampActHigh, useExtClamp;
  logic [7:0] placeCnt, widthCnt;
  logic [2:0] midSel;
  logic clampOut;
  logic [23:0] clampTarget;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  clamp_window_top dut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .syncActHigh(syncActHigh),
    .extClampIn(extClampIn), .extClampActHigh(extClampActHigh),
    .useExtClamp(useExtClamp), .placeCnt(placeCnt), .widthCnt(widthCnt),
    .midSel(midSel), .clampOut(clampOut), .clampTarget(clampTarget)
  );

  // {polarity, placement, duration}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 8'd9,  8'd20},
    {1'b1, 8'd0,  8'd5},
    {1'b0, 8'd3,  8'd1},
    {1'b1, 8'd4,  8'd0},
    {1'b0, 8'd40, 8'd10},
    {1'b0, 8'd0,  8'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setSync(input bit active);
    syncIn = active ? syncActHigh : ~syncActHigh;
  endtask

  // Runs one line and measures the window relative to the trailing edge.
  task automatic runLine(input logic [7:0] p, input logic [7:0] d, input bit pol,
                         output int first, output int cnt);
    syncActHigh = pol;
    setSync(1'b0);
    placeCnt = p;
    widthCnt = d;
    repeat (3) @(negedge clk);
    setSync(1'b1);
    repeat (4) @(negedge clk);
    check(clampOut == 1'b0, "R9 low during sync", clampOut, 0);
    setSync(1'b0);
    first = 0;
    cnt = 0;
    for (int k = 1; k <= int'(p) + int'(d) + 8; k++) begin
      @(negedge clk);
      if (clampOut) begin
        if (first == 0) first = k;
        cnt++;
      end
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int first, cnt;
    rstN = 1'b0;
    syncActHigh = 1'b1;
    syncIn = 1'b0;
    extClampIn = 1'b0;
    extClampActHigh = 1'b1;
    useExtClamp = 1'b0;
    placeCnt = 8'd9;
    widthCnt = 8'd20;
    midSel = 3'b000;
    repeat (3) @(negedge clk);
    check(clampOut == 1'b0, "R1 reset", clampOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(clampOut == 1'b0, "R1 after reset", clampOut, 0);

    // Table walk: R2, R3, R4, R5, R11-style zero placement
    foreach (VEC[i]) begin
      runLine(VEC[i][15:8], VEC[i][7:0], VEC[i][16], first, cnt);
      if (VEC[i][7:0] == 8'd0) begin
        check(cnt == 0, "R4 zero width no pulse", cnt, 0);
      end else begin
        check(first == int'(VEC[i][15:8]) + 1, "R2/R5 clamp start", first, int'(VEC[i][15:8]) + 1);
        check(cnt == int'(VEC[i][7:0]), "R3 clamp length", cnt, int'(VEC[i][7:0]));
      end
    end

    // R6: retrigger during placement wait
    syncActHigh = 1'b1;
    setSync(1'b0);
    placeCnt = 8'd10;
    widthCnt = 8'd5;
    repeat (3) @(negedge clk);
    setSync(1'b1);
    @(negedge clk);
    setSync(1'b0);
    repeat (4) @(negedge clk);
    setSync(1'b1);
    @(negedge clk);
    setSync(1'b0);
    first = 0;
    cnt = 0;
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      if (clampOut) begin
        if (first == 0) first = k;
        cnt++;
      end
    end
    check(first == 11, "R6 restart from new edge", first, 11);
    check(cnt == 5, "R6 length after restart", cnt, 5);

    // R9: leading edge aborts a running window
    placeCnt = 8'd2;
    widthCnt = 8'd20;
    setSync(1'b1);
    @(negedge clk);
    setSync(1'b0);
    repeat (6) @(negedge clk);
    check(clampOut == 1'b1, "R9 window running", clampOut, 1);
    setSync(1'b1);
    @(negedge clk);
    check(clampOut == 1'b0, "R9 cleared by sync", clampOut, 0);
    setSync(1'b0);
    @(negedge clk);
    check(clampOut == 1'b0, "R9 new window still waiting", clampOut, 0);
    repeat (30) @(negedge clk);
    check(clampOut == 1'b0, "R9 window finished", clampOut, 0);

    // R8: external pin ignored in internal mode
    extClampActHigh = 1'b1;
    extClampIn = 1'b1;
    repeat (3) @(negedge clk);
    check(clampOut == 1'b0, "R8 ext pin ignored", clampOut, 0);
    extClampIn = 1'b0;

    // R7: external mode, both polarities
    useExtClamp = 1'b1;
    @(negedge clk);
    check(clampOut == 1'b0, "R7 ext inactive", clampOut, 0);
    extClampIn = 1'b1;
    @(negedge clk);
    check(clampOut == 1'b1, "R7 ext active high", clampOut, 1);
    extClampIn = 1'b0;
    @(negedge clk);
    check(clampOut == 1'b0, "R7 ext release", clampOut, 0);
    extClampActHigh = 1'b0;
    @(negedge clk);
    check(clampOut == 1'b1, "R7 ext active low", clampOut, 1);
    setSync(1'b1);
    @(negedge clk);
    check(clampOut == 1'b0, "R9 ext gated by sync", clampOut, 0);
    setSync(1'b0);
    useExtClamp = 1'b0;
    extClampActHigh = 1'b1;
    @(negedge clk);

    // R10: target codes
    midSel = 3'b101;
    #1;
    check(clampTarget == 24'h800080, "R10 targets 101", int'(clampTarget), 24'h800080);
    midSel = 3'b010;
    #1;
    check(clampTarget == 24'h008000, "R10 targets 010", int'(clampTarget), 24'h008000);
    midSel = 3'b000;
    #1;
    check(clampTarget == 24'h000000, "R10 targets 000", int'(clampTarget), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule